// File: doc/BRIEF.md
# RF Pulse Timing Sequencer

This block paces one accelerator RF pulse at a time in the fast sample-clock domain. An external RF gate input marks the pulse. The block keeps the converters powered down between pulses and wakes them early enough for their settling time. It opens the capture and feedback windows and forces drive off the moment the gate is low. When the pulse ends it tells host software through a level interrupt.

Between pulses, software exchanges data with the signal chain and then clears a handshake flag that the block set at the end of the pulse. If the next pulse starts while that flag is still set, the block latches a sticky error, which software reads and clears. Converter wake-up is started either by a pre-trigger strobe, when one is enabled, or by the gate edge itself. Samples are marked invalid until the programmed settling count has run out. Datapath coefficients may be reloaded only while no pulse is in preparation or in progress.

Top module: `rf_pulse_sequencer`

## Requirements
- R1: The gate input passes through a SYNC_STAGES-flop synchronizer (default 2). With the default, capture_en_o rises on the third rising clock edge after gate_i is first sampled high.
- R2: drive_en_o is low in any cycle where gate_i is low, with no clock delay. It is high while a pulse is in progress and gate_i is high.
- R3: adc_sleep_o is high while idle and after a pulse has ended. It goes low on the clock edge that accepts a pre-trigger or starts a pulse from idle.
- R4: pretrig_i has no effect while pretrig_en_i is low. The converters stay asleep and coefficient loading stays enabled.
- R5: sample_valid_o is high only inside the capture window, and only once WAKE_CYCLES clock edges have passed since the converters were woken. fb_en_o equals sample_valid_o AND drive_en_o.
- R6: With the default synchronizer, three clock edges after gate_i is first sampled low during a pulse, capture_en_o falls, adc_sleep_o rises, and irq_o and hs_flag_o are both set.
- R7: irq_o stays high until an irq_ack_i cycle clears it. hs_flag_o stays high until an hs_clr_i cycle clears it. Each clear leaves the other signal unchanged.
- R8: A pulse that starts while hs_flag_o is high sets hs_err_o. hs_err_o stays set until an err_clr_i cycle clears it, and a pulse that starts with the flag clear leaves it low.
- R9: coef_load_en_o is high only when the block is idle or a pulse has ended. It is low during wake-up, while armed, and during a pulse.
- R10: After reset, adc_sleep_o and coef_load_en_o are high, and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | External RF gate; high marks the pulse |
| pretrig_en_i | input | 1 | Pre-trigger source is available |
| pretrig_i | input | 1 | One-cycle pre-trigger strobe that starts converter wake-up |
| irq_ack_i | input | 1 | Software acknowledge of the interrupt |
| hs_clr_i | input | 1 | Software clear of the handshake flag |
| err_clr_i | input | 1 | Software clear of the handshake error |
| adc_sleep_o | output | 1 | Converter power-down request |
| capture_en_o | output | 1 | Capture window open (pulse in progress) |
| sample_valid_o | output | 1 | Converters settled, samples usable |
| drive_en_o | output | 1 | RF drive output allowed |
| fb_en_o | output | 1 | Feedback loop may act |
| coef_load_en_o | output | 1 | Datapath coefficients may be reloaded |
| irq_o | output | 1 | End-of-pulse interrupt level |
| hs_flag_o | output | 1 | Handshake flag awaiting software clear |
| hs_err_o | output | 1 | Sticky handshake-missed error |

## Verification
Most state faults show up within one to three cycles on the window and power pins. A state stuck at idle keeps adc_sleep_o high past the expected wake edge. A state that misses the gate drop leaves capture_en_o high on the third edge after the fall. A settling counter that loads or decrements wrongly shifts the first sample_valid_o cycle away from exactly WAKE_CYCLES edges after wake-up. A handshake flag or error that is cleared or set wrongly becomes visible only at the start of the next pulse, so the bench runs pulse sequences with and without software clears.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAKE   = 3'd1,
    ST_ARMED  = 3'd2,
    ST_ACTIVE = 3'd3,
    ST_DONE   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DEPTH-2:0], in_i};
  end

  // last stage holds the previous synchronized level
  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int unsigned CYCLES = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic          awake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      awake_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= LOAD;
      awake_q <= 1'b1;
    end else if (stop_i) begin
      cnt_q   <= '0;
      awake_q <= 1'b0;
    end else if (awake_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = awake_q && (cnt_q == '0);
endmodule

// File: rtl/hs_monitor.sv
module hs_monitor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_start_i,
  input  logic pulse_end_i,
  input  logic irq_ack_i,
  input  logic hs_clr_i,
  input  logic err_clr_i,
  output logic irq_o,
  output logic flag_o,
  output logic err_o
);
  logic irq_q, flag_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (pulse_end_i)    irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;

      if (pulse_end_i)   flag_q <= 1'b1;
      else if (hs_clr_i) flag_q <= 1'b0;

      // set wins over clear so a miss is never lost
      if (pulse_start_i && flag_q) err_q <= 1'b1;
      else if (err_clr_i)          err_q <= 1'b0;
    end
  end

  assign irq_o  = irq_q;
  assign flag_o = flag_q;
  assign err_o  = err_q;
endmodule

// File: rtl/rf_pulse_sequencer.sv
module rf_pulse_sequencer
  import rfseq_pkg::*;
#(
  parameter int unsigned WAKE_CYCLES = 1600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic pretrig_en_i,
  input  logic pretrig_i,
  input  logic irq_ack_i,
  input  logic hs_clr_i,
  input  logic err_clr_i,
  output logic adc_sleep_o,
  output logic capture_en_o,
  output logic sample_valid_o,
  output logic drive_en_o,
  output logic fb_en_o,
  output logic coef_load_en_o,
  output logic irq_o,
  output logic hs_flag_o,
  output logic hs_err_o
);
  seq_state_e st_q, st_d;
  logic gate_rise, gate_fall;
  logic wake_start, pulse_start, pulse_end;
  logic ready, asleep, active;

  gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (gate_i),
    .rise_o (gate_rise),
    .fall_o (gate_fall)
  );

  wake_timer #(.CYCLES(WAKE_CYCLES)) u_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wake_start),
    .stop_i  (asleep),
    .ready_o (ready)
  );

  hs_monitor u_hs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pulse_start_i (pulse_start),
    .pulse_end_i   (pulse_end),
    .irq_ack_i     (irq_ack_i),
    .hs_clr_i      (hs_clr_i),
    .err_clr_i     (err_clr_i),
    .irq_o         (irq_o),
    .flag_o        (hs_flag_o),
    .err_o         (hs_err_o)
  );

  always_comb begin
    st_d        = st_q;
    wake_start  = 1'b0;
    pulse_start = 1'b0;
    pulse_end   = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (gate_rise) begin
          // no pre-trigger seen: wake on the gate edge itself
          st_d        = ST_ACTIVE;
          wake_start  = 1'b1;
          pulse_start = 1'b1;
        end else if (pretrig_en_i && pretrig_i) begin
          st_d       = ST_WAKE;
          wake_start = 1'b1;
        end else if (st_q == ST_DONE && !hs_flag_o) begin
          st_d = ST_IDLE;
        end
      end
      ST_WAKE: begin
        if (gate_rise) begin
          st_d        = ST_ACTIVE;
          pulse_start = 1'b1;
        end else if (ready) begin
          st_d = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (gate_rise) begin
          st_d        = ST_ACTIVE;
          pulse_start = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (gate_fall) begin
          st_d      = ST_DONE;
          pulse_end = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign asleep         = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign active         = (st_q == ST_ACTIVE);
  assign adc_sleep_o    = asleep;
  assign coef_load_en_o = asleep;
  assign capture_en_o   = active;
  assign sample_valid_o = active && ready;
  // raw gate: drive is cut without waiting for the synchronizer
  assign drive_en_o     = active && gate_i;
  assign fb_en_o        = sample_valid_o && drive_en_o;
endmodule

// File: rtl/rf_pulse_sequencer_chk.sv
module rf_pulse_sequencer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic gate_i,
  input logic pretrig_en_i,
  input logic pretrig_i,
  input logic irq_ack_i,
  input logic hs_clr_i,
  input logic err_clr_i,
  input logic adc_sleep_o,
  input logic capture_en_o,
  input logic sample_valid_o,
  input logic drive_en_o,
  input logic fb_en_o,
  input logic coef_load_en_o,
  input logic irq_o,
  input logic hs_flag_o,
  input logic hs_err_o
);
  AST_DRIVE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |-> gate_i && capture_en_o); // R2

  AST_SLEEP_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_sleep_o |-> !capture_en_o); // R3

  AST_VALID_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> capture_en_o && !adc_sleep_o); // R5

  AST_FB_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_en_o |-> sample_valid_o && drive_en_o); // R5

  AST_END_SIGNALS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(capture_en_o) |-> irq_o && hs_flag_o && adc_sleep_o); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_flag_o && !hs_clr_i |=> hs_flag_o); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_err_o && !err_clr_i |=> hs_err_o); // R8

  AST_COEF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_load_en_o |-> adc_sleep_o && !capture_en_o); // R9
endmodule

bind rf_pulse_sequencer rf_pulse_sequencer_chk u_chk (.*);

// File: tb/rf_pulse_sequencer_bench.sv
module rf_pulse_sequencer_bench;
  localparam int W = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic gate_i = 1'b0, pretrig_en_i = 1'b0, pretrig_i = 1'b0;
  logic irq_ack_i = 1'b0, hs_clr_i = 1'b0, err_clr_i = 1'b0;
  logic adc_sleep_o, capture_en_o, sample_valid_o, drive_en_o, fb_en_o;
  logic coef_load_en_o, irq_o, hs_flag_o, hs_err_o;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit exp_flag = 1'b0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  rf_pulse_sequencer #(.WAKE_CYCLES(W)) u_rf_pulse_sequencer (.*);

  task automatic tick();
    @(posedge clk_i);
    #2;
    cyc++;
  endtask

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit exp_valid(input int now, input int wake_at);
    return (now - wake_at) >= W;
  endfunction

  task automatic run_pulse(input bit use_pre, input int lead, input int len, input bit exp_err);
    int ws;
    ws = 0;
    pretrig_en_i = use_pre;
    if (use_pre) begin
      pretrig_i = 1'b1;
      tick();
      pretrig_i = 1'b0;
      ws = cyc;
      chk(adc_sleep_o, 1'b0, "R3", "awake after pre-trigger");
      chk(coef_load_en_o, 1'b0, "R9", "coef load during wake");
      for (int i = 0; i < lead; i++) tick();
    end
    gate_i = 1'b1;
    tick(); tick();
    chk(capture_en_o, 1'b0, "R1", "capture before sync latency");
    tick();
    chk(capture_en_o, 1'b1, "R1", "capture after sync latency");
    chk(coef_load_en_o, 1'b0, "R9", "coef load in pulse");
    chk(hs_err_o, exp_err, "R8", "error at pulse start");
    if (!use_pre) begin
      ws = cyc;
      chk(adc_sleep_o, 1'b0, "R3", "awake on gate edge");
    end
    for (int i = 0; i < len; i++) begin
      chk(sample_valid_o, exp_valid(cyc, ws), "R5", "sample valid timing");
      chk(fb_en_o, exp_valid(cyc, ws), "R5", "feedback enable");
      chk(drive_en_o, 1'b1, "R2", "drive with gate high");
      tick();
    end
    gate_i = 1'b0;
    #1;
    chk(drive_en_o, 1'b0, "R2", "drive cut on gate low");
    chk(fb_en_o, 1'b0, "R5", "feedback off with drive");
    tick(); tick();
    chk(capture_en_o, 1'b1, "R6", "capture held during sync");
    tick();
    chk(capture_en_o, 1'b0, "R6", "capture closed");
    chk(adc_sleep_o, 1'b1, "R6", "sleep after pulse");
    chk(irq_o, 1'b1, "R6", "interrupt raised");
    chk(hs_flag_o, 1'b1, "R6", "handshake flag set");
    chk(coef_load_en_o, 1'b1, "R9", "coef load after pulse");
    exp_flag = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    chk(adc_sleep_o, 1'b1, "R10", "reset sleep");
    chk(coef_load_en_o, 1'b1, "R10", "reset coef load");
    chk(capture_en_o, 1'b0, "R10", "reset capture");
    chk(sample_valid_o, 1'b0, "R10", "reset valid");
    chk(drive_en_o, 1'b0, "R10", "reset drive");
    chk(irq_o, 1'b0, "R10", "reset irq");
    chk(hs_flag_o, 1'b0, "R10", "reset flag");
    chk(hs_err_o, 1'b0, "R10", "reset error");

    // pre-trigger with source disabled
    pretrig_en_i = 1'b0;
    pretrig_i = 1'b1;
    tick();
    pretrig_i = 1'b0;
    chk(adc_sleep_o, 1'b1, "R4", "disabled pre-trigger keeps sleep");
    chk(coef_load_en_o, 1'b1, "R4", "disabled pre-trigger keeps coef load");
    tick();
    chk(adc_sleep_o, 1'b1, "R4", "still asleep");

    // wake on gate edge, valid partway through
    run_pulse(1'b0, 0, 30, 1'b0);

    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    chk(irq_o, 1'b0, "R7", "irq cleared by ack");
    chk(hs_flag_o, 1'b1, "R7", "flag kept after irq ack");
    repeat (5) tick();
    chk(hs_flag_o, 1'b1, "R7", "flag still held");

    // handshake missed; long pre-trigger lead gives valid from first cycle
    run_pulse(1'b1, W + 5, 10, 1'b1);
    repeat (4) tick();
    chk(hs_err_o, 1'b1, "R8", "error sticky");
    chk(irq_o, 1'b1, "R7", "irq held without ack");
    err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
    chk(hs_err_o, 1'b0, "R8", "error cleared");
    hs_clr_i = 1'b1; tick(); hs_clr_i = 1'b0;
    chk(hs_flag_o, 1'b0, "R7", "flag cleared");
    chk(irq_o, 1'b1, "R7", "irq kept after flag clear");
    exp_flag = 1'b0;
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    repeat (3) tick();

    // short lead: gate arrives while still settling
    run_pulse(1'b1, 2, 25, 1'b0);
    hs_clr_i = 1'b1; tick(); hs_clr_i = 1'b0;
    exp_flag = 1'b0;
    repeat (3) tick();

    for (int k = 0; k < 14; k++) begin
      bit pre, clr;
      int lead, len;
      pre  = 1'($urandom_range(1, 0));
      clr  = 1'($urandom_range(1, 0));
      lead = $urandom_range(W + 10, 0);
      len  = $urandom_range(40, 1);
      run_pulse(pre, lead, len, exp_flag);
      irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
      if (clr) begin
        hs_clr_i = 1'b1; tick(); hs_clr_i = 1'b0;
        exp_flag = 1'b0;
        chk(hs_flag_o, 1'b0, "R7", "random flag clear");
      end
      err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
      chk(hs_err_o, 1'b0, "R8", "random error clear");
      repeat ($urandom_range(6, 3)) tick();
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule